// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two signed operands and adds the product to a 64-bit signed accumulator. The accumulator is kept as a high word (bits 63..32) and a low word (bits 31..0), and both words are visible at the outputs. A mode input selects one of two operand sizes. Long mode multiplies the full 32-bit operands. Word mode multiplies only the low 16 bits of each operand.

A saturation-enable input selects what happens when a sum goes out of range, and the rule differs by mode. In word mode the result is clamped to the signed 32-bit range, and the high word is set to 1 to mark that a clamp occurred. In long mode the result is limited to a signed 48-bit range: the top 16 bits of the high word always repeat bit 47. With saturation disabled, both modes wrap modulo 2^64.

The host core drives one accumulate per cycle with a valid strobe. It zeroes the accumulator with a clear input and writes either half directly through load strobes. Every update is registered and becomes visible one clock edge after the strobe.

Top module: `mac_sat_unit`

## Requirements
- R1: After reset, both accumulator words read 0x00000000.
- R2: In long mode (mode_word=0), the signed 32x32 product is added to the signed 64-bit accumulator. With sat_en=0 the sum wraps modulo 2^64.
- R3: In word mode (mode_word=1), only bits 15..0 of each operand are used, as signed 16-bit values. Bits 31..16 of the operands have no effect.
- R4: In word mode with sat_en=1, a sum above 2^31-1 produces a high word of 0x00000001 and a low word of 0x7FFFFFFF.
- R5: In word mode with sat_en=1, a sum below -2^31 produces a high word of 0x00000001 and a low word of 0x80000000.
- R6: In word mode with sat_en=1, a sum within [-2^31, 2^31-1] is written unchanged, with the high word holding the sign extension.
- R7: In long mode with sat_en=1, a sum above 2^47-1 is written as 0x00007FFF_FFFFFFFF. A sum inside the 48-bit range is written unchanged, so bits 63..48 repeat bit 47.
- R8: In long mode with sat_en=1, a sum below -2^47 is written as 0xFFFF8000_00000000.
- R9: clr_acc zeroes both words at the next edge. It takes priority over the load strobes and over the accumulate strobe.
- R10: ld_hi writes ld_data into the high word and ld_lo writes ld_data into the low word; the other half is kept. A load in the same cycle as acc_valid takes priority, and the accumulate is dropped.
- R11: While acc_valid, clr_acc, ld_hi and ld_lo are all low, both words hold their values, whatever the operand inputs are.
- R12: An accumulate completes in one cycle. The outputs keep their old value until the clock edge that samples acc_valid, and show the new sum right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Perform one multiply-accumulate this cycle |
| mode_word | input | 1 | 1 selects 16x16 word mode, 0 selects 32x32 long mode |
| sat_en | input | 1 | Enables the saturation rule of the selected mode |
| op_a | input | 32 | First signed operand |
| op_b | input | 32 | Second signed operand |
| clr_acc | input | 1 | Zero both accumulator words |
| ld_hi | input | 1 | Write ld_data into the high word |
| ld_lo | input | 1 | Write ld_data into the low word |
| ld_data | input | 32 | Data for the load strobes |
| acc_hi | output | 32 | Accumulator bits 63..32 |
| acc_lo | output | 32 | Accumulator bits 31..0 |

## Verification
The accumulator registers drive the outputs directly, so a wrong product, a wrong sign extension or a wrong clamp decision shows on acc_hi or acc_lo one edge after the strobe. Because every later sum builds on the stored value, such an error also stays visible in later cycles. A clamp fault only shows near a range boundary, so the tests preload values just inside a limit with the load strobes and then cross the limit with a small product. Priority faults show as a nonzero or half-changed accumulator in the cycle after clear, load and accumulate are strobed together.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int DATA_W     = 32;
    localparam int HALF_W     = 16;
    localparam int LONG_SAT_W = 48;
    localparam int ACC_W      = 2 * DATA_W;

    typedef enum logic {
        MODE_LONG = 1'b0,
        MODE_WORD = 1'b1
    } mac_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
    } acc_state_t;
endpackage

// File: rtl/mac_product.sv
module mac_product
    import mac_pkg::*;
#(
    parameter int OP_W   = DATA_W,
    parameter int NARROW = HALF_W,
    parameter int PROD_W = 2 * OP_W
) (
    input  mac_mode_e          mode,
    input  logic [OP_W-1:0]    a,
    input  logic [OP_W-1:0]    b,
    output logic [PROD_W-1:0]  prod
);
    localparam int EXT_N = PROD_W - NARROW;
    localparam int EXT_W = PROD_W - OP_W;

    logic signed [PROD_W-1:0] ext_a;
    logic signed [PROD_W-1:0] ext_b;

    always_comb begin
        if (mode == MODE_WORD) begin
            ext_a = {{EXT_N{a[NARROW-1]}}, a[NARROW-1:0]};
            ext_b = {{EXT_N{b[NARROW-1]}}, b[NARROW-1:0]};
        end else begin
            ext_a = {{EXT_W{a[OP_W-1]}}, a};
            ext_b = {{EXT_W{b[OP_W-1]}}, b};
        end
        prod = ext_a * ext_b;
    end
endmodule

// File: rtl/mac_saturate.sv
module mac_saturate
    import mac_pkg::*;
#(
    parameter int W      = DATA_W,
    parameter int LSAT_W = LONG_SAT_W,
    parameter int AW     = 2 * W
) (
    input  mac_mode_e        mode,
    input  logic             sat_en,
    input  logic [AW-1:0]    acc,
    input  logic [AW-1:0]    prod,
    output logic [AW-1:0]    result
);
    localparam int SUM_W = AW + 1;
    localparam logic signed [SUM_W-1:0] ONE   = 1;
    localparam logic signed [SUM_W-1:0] W_MAX = (ONE <<< (W - 1)) - ONE;
    localparam logic signed [SUM_W-1:0] W_MIN = -(ONE <<< (W - 1));
    localparam logic signed [SUM_W-1:0] L_MAX = (ONE <<< (LSAT_W - 1)) - ONE;
    localparam logic signed [SUM_W-1:0] L_MIN = -(ONE <<< (LSAT_W - 1));
    localparam logic [W-1:0] MARK_HI = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] LO_POS  = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] LO_NEG  = {1'b1, {(W-1){1'b0}}};

    logic signed [SUM_W-1:0] sum;

    always_comb begin
        sum    = $signed({acc[AW-1], acc}) + $signed({prod[AW-1], prod});
        result = sum[AW-1:0];
        if (sat_en) begin
            if (mode == MODE_WORD) begin
                if (sum > W_MAX) begin
                    result = {MARK_HI, LO_POS};
                end else if (sum < W_MIN) begin
                    result = {MARK_HI, LO_NEG};
                end
            end else begin
                if (sum > L_MAX) begin
                    result = L_MAX[AW-1:0];
                end else if (sum < L_MIN) begin
                    result = L_MIN[AW-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
    import mac_pkg::*;
#(
    parameter int W      = DATA_W,
    parameter int NARROW = HALF_W,
    parameter int LSAT_W = LONG_SAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic          mode_word,
    input  logic          sat_en,
    input  logic [31:0]   op_a,
    input  logic [31:0]   op_b,
    input  logic          clr_acc,
    input  logic          ld_hi,
    input  logic          ld_lo,
    input  logic [31:0]   ld_data,
    output logic [31:0]   acc_hi,
    output logic [31:0]   acc_lo
);
    localparam int AW     = 2 * W;
    localparam int SAT_LO = LSAT_W - W - 1;

    acc_state_t        state_d, state_q;
    mac_mode_e         mode;
    logic [AW-1:0]     prod;
    logic [AW-1:0]     acc_next;

    assign mode = mac_mode_e'(mode_word);

    mac_product #(.OP_W(W), .NARROW(NARROW), .PROD_W(AW)) u_prod (
        .mode (mode),
        .a    (op_a),
        .b    (op_b),
        .prod (prod)
    );

    mac_saturate #(.W(W), .LSAT_W(LSAT_W), .AW(AW)) u_sat (
        .mode   (mode),
        .sat_en (sat_en),
        .acc    ({state_q.hi, state_q.lo}),
        .prod   (prod),
        .result (acc_next)
    );

    always_comb begin
        state_d = state_q;
        if (clr_acc) begin
            state_d = '0;
        end else if (ld_hi || ld_lo) begin
            if (ld_hi) state_d.hi = ld_data;
            if (ld_lo) state_d.lo = ld_data;
        end else if (acc_valid) begin
            state_d.hi = acc_next[AW-1:W];
            state_d.lo = acc_next[W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign acc_hi = state_q.hi;
    assign acc_lo = state_q.lo;

    // R9: clear wins over every other control
    a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_acc |=> (acc_hi == '0 && acc_lo == '0));

    // R10: high-word load takes the data bus value
    a_r10_load_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_hi && !clr_acc) |=> (acc_hi == $past(ld_data)));

    // R11: idle cycles keep the accumulator
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && !clr_acc && !ld_hi && !ld_lo) |=> ($stable(acc_hi) && $stable(acc_lo)));

    // R7, R8: long saturated results stay in the 48-bit signed range
    a_r7_long_sat_range: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !mode_word && sat_en && !clr_acc && !ld_hi && !ld_lo)
        |=> (acc_hi[W-1:SAT_LO] == '0 || acc_hi[W-1:SAT_LO] == '1));

    // R4, R5, R6: word saturated results are a marker clamp or a sign-extended 32-bit value
    a_r4_word_sat_form: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && mode_word && sat_en && !clr_acc && !ld_hi && !ld_lo)
        |=> ((acc_hi == 32'd1 && (acc_lo == 32'h7FFF_FFFF || acc_lo == 32'h8000_0000))
             || (acc_hi == '0 && !acc_lo[W-1])
             || (acc_hi == '1 && acc_lo[W-1])));
endmodule

// File: tb/tb_mac_sat_unit.sv
module tb_mac_sat_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        mode_word = 1'b0;
    logic        sat_en = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        clr_acc = 1'b0;
    logic        ld_hi = 1'b0;
    logic        ld_lo = 1'b0;
    logic [31:0] ld_data = '0;
    logic [31:0] acc_hi;
    logic [31:0] acc_lo;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_sat_unit dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .mode_word(mode_word),
        .sat_en(sat_en), .op_a(op_a), .op_b(op_b), .clr_acc(clr_acc),
        .ld_hi(ld_hi), .ld_lo(ld_lo), .ld_data(ld_data),
        .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    task automatic check(input string req, input logic [31:0] exp_hi, input logic [31:0] exp_lo);
        checks++;
        if (acc_hi !== exp_hi || acc_lo !== exp_lo) begin
            errors++;
            $display("FAIL %s: got %08h_%08h expected %08h_%08h", req, acc_hi, acc_lo, exp_hi, exp_lo);
        end
    endtask

    task automatic idle();
        acc_valid = 0; clr_acc = 0; ld_hi = 0; ld_lo = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic do_clear();
        clr_acc = 1; step();
    endtask

    task automatic do_load(input logic hi_sel, input logic [31:0] d);
        ld_hi = hi_sel; ld_lo = !hi_sel; ld_data = d; step();
    endtask

    task automatic do_mac(input logic wmode, input logic sat, input logic [31:0] a, input logic [31:0] b);
        acc_valid = 1; mode_word = wmode; sat_en = sat; op_a = a; op_b = b; step();
    endtask

    task automatic t_long_basic();
        do_clear();
        acc_valid = 1; mode_word = 0; sat_en = 0; op_a = 32'hFFFF_FFFD; op_b = 32'd7;
        #1 check("R12 before edge", 32'h0, 32'h0);
        step();
        check("R2 neg product", 32'hFFFF_FFFF, 32'hFFFF_FFEB);
        do_mac(0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        check("R2 large product", 32'h3FFF_FFFE, 32'hFFFF_FFEC);
    endtask

    task automatic t_wrap_and_load();
        do_clear();
        do_load(1, 32'h7FFF_FFFF);
        check("R10 load hi", 32'h7FFF_FFFF, 32'h0);
        do_load(0, 32'hFFFF_FFFF);
        check("R10 load lo", 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        do_mac(0, 0, 32'd1, 32'd1);
        check("R2 wrap", 32'h8000_0000, 32'h0);
    endtask

    task automatic t_word_operands();
        do_clear();
        do_mac(1, 0, 32'hABCD_0003, 32'h1234_FFFE);
        check("R3 upper bits ignored", 32'hFFFF_FFFF, 32'hFFFF_FFFA);
    endtask

    task automatic t_word_sat();
        do_clear();
        do_load(0, 32'h7FFF_FFF0);
        do_mac(1, 1, 32'd4, 32'd5);
        check("R4 upper clamp", 32'h1, 32'h7FFF_FFFF);
        do_mac(1, 1, 32'd1, 32'd1);
        check("R4 stays clamped", 32'h1, 32'h7FFF_FFFF);
        do_clear();
        do_load(1, 32'hFFFF_FFFF);
        do_load(0, 32'h8000_0002);
        do_mac(1, 1, 32'h0000_FFFE, 32'd2);
        check("R5 lower clamp", 32'h1, 32'h8000_0000);
        do_clear();
        do_mac(1, 1, 32'h0000_7FFF, 32'h0000_7FFF);
        check("R6 in range pos", 32'h0, 32'h3FFF_0001);
        do_mac(1, 1, 32'h0000_8000, 32'h0000_7FFF);
        check("R6 in range neg", 32'hFFFF_FFFF, 32'hFFFF_8001);
    endtask

    task automatic t_long_sat();
        do_clear();
        do_load(1, 32'h0000_7FFF);
        do_load(0, 32'hFFFF_FFF0);
        do_mac(0, 1, 32'h100, 32'd1);
        check("R7 upper clamp", 32'h0000_7FFF, 32'hFFFF_FFFF);
        do_clear();
        do_mac(0, 1, 32'hFFFF_FFFF, 32'd1);
        check("R7 in range", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        do_clear();
        do_load(1, 32'hFFFF_8000);
        do_load(0, 32'h0000_0005);
        do_mac(0, 1, 32'hFFFF_FFF0, 32'd1);
        check("R8 lower clamp", 32'hFFFF_8000, 32'h0);
    endtask

    task automatic t_priority_hold();
        do_clear();
        do_mac(0, 0, 32'd9, 32'd9);
        clr_acc = 1; ld_hi = 1; ld_data = 32'h1234_5678; acc_valid = 1; op_a = 5; op_b = 5;
        step();
        check("R9 clear priority", 32'h0, 32'h0);
        do_mac(0, 0, 32'd3, 32'd3);
        ld_lo = 1; ld_data = 32'hCAFE_0000; acc_valid = 1; op_a = 100; op_b = 100;
        step();
        check("R10 load beats accumulate", 32'h0, 32'hCAFE_0000);
        op_a = 32'hFFFF_FFFF; op_b = 32'h7777_7777; sat_en = 1; mode_word = 1;
        step();
        step();
        check("R11 idle hold", 32'h0, 32'hCAFE_0000);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 reset value", 32'h0, 32'h0);
        rst_n = 1;
        @(negedge clk);
        check("R1 after release", 32'h0, 32'h0);
        t_long_basic();
        t_wrap_and_load();
        t_word_operands();
        t_word_sat();
        t_long_sat();
        t_priority_hold();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule